// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter with Byte Lanes

This block separates a processor bus that carries the address and the data on the same lines. It drives a plain address bus and a 16-bit data bus with per-byte enables for memory. While the address-latch strobe is high, the block captures the shared lines and the bus-high-enable input (active low) into a register clocked by the system clock. This makes the capture transparent in effect without a real latch. When the strobe falls, the captured address is held while the shared lines go on to carry data.

The captured bus-high-enable bit and the captured address bit 0 form a two-bit lane code. It selects the whole word, the odd (high) byte alone, the even (low) byte alone, or nothing. The code is turned into read and write byte enables only while exactly one of the read and write strobes (both active low) is asserted. Write data is passed only on enabled lanes. Read data from memory is steered back to the processor. A lone odd byte is also copied onto the low lane, so that a consumer that reads eight bits finds it there.

The interface is a plain synchronous bus with no handshake. An access lasts as long as its strobe is held, and the block applies no back-pressure.

Top module: `mux_bus_splitter`

## Requirements
- R1: On every rising clock edge at which `ale_i` is high, `addr_o` takes the value of `ad_bus_i` in the next cycle.
- R2: On a rising clock edge at which `ale_i` is low, `addr_o` keeps its value, however `ad_bus_i` changes.
- R3: The lane code is {captured `bhe_n_i`, `addr_o[0]`}. Code 00 selects both lanes (enable 2'b11). Code 01 selects the high lane only (2'b10). Code 10 selects the low lane only (2'b01). Code 11 selects no lane (2'b00). Bit 1 of an enable is the high byte, data bits 15:8.
- R4: `rd_be_o` equals the lane mask when `rd_n_i` is low and `wr_n_i` is high, and is 0 otherwise. `wr_be_o` equals the lane mask when `wr_n_i` is low and `rd_n_i` is high, and is 0 otherwise. When both strobes are low, both enables are 0.
- R5: `cpu_rdata_o` is `mem_rdata_i` for a word read. It is {`mem_rdata_i[15:8]`, `mem_rdata_i[15:8]`} for an odd-byte read and {8'h00, `mem_rdata_i[7:0]`} for an even-byte read. It is 0 when no read lane is enabled.
- R6: Each byte lane of `wdata_o` carries the same lane of `ad_bus_i[15:0]` when its write enable is set, and is 0 otherwise.
- R7: After reset, `addr_o` is 0, both enables are 0, and the captured bus-high-enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_bus_i | input | ADDR_W | Shared address/data lines; bits 15:0 carry data in the data phase |
| ale_i | input | 1 | Address capture strobe, active high |
| bhe_n_i | input | 1 | Bus-high-enable, active low, captured with the address |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| mem_rdata_i | input | 16 | Read data from memory |
| addr_o | output | ADDR_W | Captured address |
| rd_be_o | output | 2 | Read byte enables, bit 1 = high byte |
| wr_be_o | output | 2 | Write byte enables, bit 1 = high byte |
| wdata_o | output | 16 | Write data to memory, disabled lanes zero |
| cpu_rdata_o | output | 16 | Steered read data to the processor |

## Verification
The hardest case to reach from the ports is a data phase in which the shared lines carry a value whose bit 0 and upper bits differ from the captured address, while a strobe is active. Only in that case does decoding from the live pins instead of the held copy give a different answer. The stimulus therefore always places a write or filler pattern on the shared lines after the strobe falls, with bit 0 inverted from the address. It runs all four lane codes for both reads and writes this way. Each access is followed by an idle cycle and then a cycle with both strobes low, so that leftover enables or read data would show.

// File: rtl/msplit_pkg.sv
package msplit_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  // {captured bus-high-enable (active low), address bit 0}
  typedef enum logic [1:0] {
    LC_WORD = 2'b00,
    LC_ODD  = 2'b01,
    LC_EVEN = 2'b10,
    LC_NONE = 2'b11
  } lane_code_e;

  function automatic logic [LANES-1:0] code_to_mask(lane_code_e c);
    case (c)
      LC_WORD: code_to_mask = 2'b11;
      LC_ODD:  code_to_mask = 2'b10;
      LC_EVEN: code_to_mask = 2'b01;
      default: code_to_mask = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/msplit_addr_capture.sv
module msplit_addr_capture
  import msplit_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] ad_i,
  input  logic              bhe_n_i,
  output logic [ADDR_W-1:0] addr_o,
  output lane_code_e        code_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              bhe_n_q;

  // Enabled register stands in for a level-sensitive latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      bhe_n_q <= 1'b1;
    end else if (ale_i) begin
      addr_q  <= ad_i;
      bhe_n_q <= bhe_n_i;
    end
  end

  assign addr_o = addr_q;
  assign code_o = lane_code_e'({bhe_n_q, addr_q[0]});
endmodule

// File: rtl/msplit_lane_decode.sv
module msplit_lane_decode
  import msplit_pkg::*;
(
  input  lane_code_e       code_i,
  input  logic             rd_n_i,
  input  logic             wr_n_i,
  output logic [LANES-1:0] rd_be_o,
  output logic [LANES-1:0] wr_be_o
);
  logic [LANES-1:0] mask;
  logic             rd_only, wr_only;

  assign mask    = code_to_mask(code_i);
  assign rd_only = !rd_n_i && wr_n_i;
  assign wr_only = !wr_n_i && rd_n_i;

  always_comb begin
    rd_be_o = rd_only ? mask : '0;
    wr_be_o = wr_only ? mask : '0;
  end
endmodule

// File: rtl/msplit_data_steer.sv
module msplit_data_steer
  import msplit_pkg::*;
(
  input  logic [LANES-1:0]  rd_be_i,
  input  logic [LANES-1:0]  wr_be_i,
  input  logic [DATA_W-1:0] ad_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_wlane
    assign wdata_o[g*LANE_W +: LANE_W] =
      wr_be_i[g] ? ad_data_i[g*LANE_W +: LANE_W] : '0;
  end

  logic [LANE_W-1:0] hi_byte, lo_byte;
  assign hi_byte = mem_rdata_i[DATA_W-1 -: LANE_W];
  assign lo_byte = mem_rdata_i[LANE_W-1:0];

  always_comb begin
    case (rd_be_i)
      2'b11:   rdata_o = mem_rdata_i;
      2'b10:   rdata_o = {hi_byte, hi_byte};
      2'b01:   rdata_o = {{LANE_W{1'b0}}, lo_byte};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mux_bus_splitter.sv
module mux_bus_splitter
  import msplit_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ad_bus_i,
  input  logic              ale_i,
  input  logic              bhe_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [15:0]       mem_rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        rd_be_o,
  output logic [1:0]        wr_be_o,
  output logic [15:0]       wdata_o,
  output logic [15:0]       cpu_rdata_o
);
  lane_code_e code;

  msplit_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_i   (ale_i),
    .ad_i    (ad_bus_i),
    .bhe_n_i (bhe_n_i),
    .addr_o  (addr_o),
    .code_o  (code)
  );

  msplit_lane_decode u_dec (
    .code_i  (code),
    .rd_n_i  (rd_n_i),
    .wr_n_i  (wr_n_i),
    .rd_be_o (rd_be_o),
    .wr_be_o (wr_be_o)
  );

  msplit_data_steer u_steer (
    .rd_be_i     (rd_be_o),
    .wr_be_i     (wr_be_o),
    .ad_data_i   (ad_bus_i[DATA_W-1:0]),
    .mem_rdata_i (mem_rdata_i),
    .wdata_o     (wdata_o),
    .rdata_o     (cpu_rdata_o)
  );
endmodule

// File: rtl/mux_bus_splitter_chk.sv
module mux_bus_splitter_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ad_bus_i,
  input logic              ale_i,
  input logic              rd_n_i,
  input logic              wr_n_i,
  input logic [15:0]       mem_rdata_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        rd_be_o,
  input logic [1:0]        wr_be_o,
  input logic [15:0]       wdata_o,
  input logic [15:0]       cpu_rdata_o
);
  // R1
  capture_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_i |=> addr_o == $past(ad_bus_i));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_i |=> $stable(addr_o));

  // R4
  idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n_i == wr_n_i) |-> (rd_be_o == 2'b00 && wr_be_o == 2'b00));

  // R5
  odd_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_be_o == 2'b10) |-> (cpu_rdata_o[7:0] == mem_rdata_i[15:8]
                            && cpu_rdata_o[15:8] == mem_rdata_i[15:8]));

  // R6
  wlane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_be_o[0] |-> (wdata_o[7:0] == 8'h00));

  // R6
  wlane_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_be_o[1] |-> (wdata_o[15:8] == ad_bus_i[15:8]));
endmodule

bind mux_bus_splitter mux_bus_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ad_bus_i    (ad_bus_i),
  .ale_i       (ale_i),
  .rd_n_i      (rd_n_i),
  .wr_n_i      (wr_n_i),
  .mem_rdata_i (mem_rdata_i),
  .addr_o      (addr_o),
  .rd_be_o     (rd_be_o),
  .wr_be_o     (wr_be_o),
  .wdata_o     (wdata_o),
  .cpu_rdata_o (cpu_rdata_o)
);

// File: tb/mux_bus_splitter_bench.sv
module mux_bus_splitter_bench;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ad_bus = '0;
  logic          ale = 1'b0, bhe_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0]   mem_rdata = '0;
  logic [AW-1:0] addr;
  logic [1:0]    rd_be, wr_be;
  logic [15:0]   wdata, rdata;

  always #2.5 clk = ~clk;

  mux_bus_splitter #(.ADDR_W(AW)) u_mux_bus_splitter (
    .clk(clk), .rst_n(rst_n), .ad_bus_i(ad_bus), .ale_i(ale),
    .bhe_n_i(bhe_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .mem_rdata_i(mem_rdata),
    .addr_o(addr), .rd_be_o(rd_be), .wr_be_o(wr_be), .wdata_o(wdata),
    .cpu_rdata_o(rdata)
  );

  typedef struct {
    string         tag;
    logic [AW-1:0] addr;
    logic [1:0]    rd_be;
    logic [1:0]    wr_be;
    logic [15:0]   wdata;
    logic [15:0]   rdata;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, fails = 0;
  bit   done = 0;

  function automatic logic [1:0] lane_mask(logic b, logic a0);
    case ({b, a0})
      2'b00:   return 2'b11;  // word
      2'b01:   return 2'b10;  // odd, high lane
      2'b10:   return 2'b01;  // even, low lane
      default: return 2'b00;  // none
    endcase
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      cmp(e.tag, "addr",  32'(addr),  32'(e.addr));
      cmp(e.tag, "rd_be", 32'(rd_be), 32'(e.rd_be));
      cmp(e.tag, "wr_be", 32'(wr_be), 32'(e.wr_be));
      cmp(e.tag, "wdata", 32'(wdata), 32'(e.wdata));
      cmp(e.tag, "rdata", 32'(rdata), 32'(e.rdata));
    end
  end

  task automatic push(string tag, logic [AW-1:0] a, logic [1:0] rb, logic [1:0] wb,
                      logic [15:0] wd, logic [15:0] rd);
    exp_t e;
    e.tag = tag; e.addr = a; e.rd_be = rb; e.wr_be = wb; e.wdata = wd; e.rdata = rd;
    exp_q.push_back(e);
  endtask

  // Driver: address phase, data phase (shared lines change), idle, both strobes
  task automatic access(logic [AW-1:0] a, logic b, bit is_wr,
                        logic [15:0] d, logic [15:0] m);
    logic [1:0]  mk;
    logic [15:0] ew, er;
    mk = lane_mask(b, a[0]);
    @(posedge clk); #1;
    ale = 1'b1; ad_bus = a; bhe_n = b;
    @(posedge clk); #1;
    ale = 1'b0;
    bhe_n = ~b;
    ad_bus = {~a[AW-1:16], d[15:1], ~a[0]};
    d = {d[15:1], ~a[0]};
    mem_rdata = m;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    ew = is_wr ? {mk[1] ? d[15:8] : 8'h00, mk[0] ? d[7:0] : 8'h00} : 16'h0;
    if (is_wr || mk == 2'b00) er = 16'h0;
    else if (mk == 2'b11) er = m;
    else if (mk == 2'b10) er = {m[15:8], m[15:8]};
    else er = {8'h00, m[7:0]};
    // R2 R3 R4 R5 R6: held address, lane code decode, steered data
    push(is_wr ? "R3/R6 write" : "R3/R5 read", a,
         is_wr ? 2'b00 : mk, is_wr ? mk : 2'b00, ew, er);
    @(posedge clk); #1;
    rd_n = 1'b1; wr_n = 1'b1;
    // R4: no strobe, no enable
    push("R4 idle", a, 2'b00, 2'b00, 16'h0, 16'h0);
    @(posedge clk); #1;
    rd_n = 1'b0; wr_n = 1'b0;
    // R4: both strobes low gives no enable
    push("R4 both strobes", a, 2'b00, 2'b00, 16'h0, 16'h0);
    @(posedge clk); #1;
    rd_n = 1'b1; wr_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state
    push("R7 reset", '0, 2'b00, 2'b00, 16'h0, 16'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a;
      a = 20'h3A5C0 + AW'(i * 20'h01235) + AW'(i & 1);
      access({a[AW-1:1], i[0]}, i[1], i[2], 16'hC3A0 ^ 16'(i * 16'h1111),
             16'hB71E ^ 16'(i * 16'h0F0F));
    end
    // R1: capture follows the shared lines while the strobe stays high
    @(posedge clk); #1;
    ale = 1'b1; ad_bus = 20'h12345;
    @(posedge clk); #1;
    ad_bus = 20'hABCDE;
    push("R1 capture first", 20'h12345, 2'b00, 2'b00, 16'h0, 16'h0);
    @(posedge clk); #1;
    ale = 1'b0; ad_bus = 20'h0F0F0;
    push("R1 capture second", 20'hABCDE, 2'b00, 2'b00, 16'h0, 16'h0);
    @(posedge clk); #1;
    push("R2 hold", 20'hABCDE, 2'b00, 2'b00, 16'h0, 16'h0);
    repeat (2) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule